// File: doc/BRIEF.md
# QAM Constellation Bit Re-arranger

A streaming stage that sits after the TTI interleaver and reorders or inverts the bits of each modulation group before symbol mapping. Bits arrive one per handshake on a valid/ready input. The stage collects one group (four bits for 16QAM, six for 64QAM), applies the selected constellation version, and replays the group on a valid/ready output. In QPSK mode every bit is its own group and passes through untouched.

A one-cycle pulse on `tti_start_i` captures the modulation code and the 2-bit constellation version for the coming TTI. The capture only happens while no partial group is held, so a stray pulse in the middle of a TTI cannot corrupt the grouping. The input bit flagged with `in_last_i` closes the TTI. If it leaves an incomplete group, those bits are forwarded unchanged and an error pulse is raised.

Top module: `qam_bit_rearranger`

## Requirements
- R1: After reset `out_valid_o` and `err_partial_o` are 0 and `in_ready_o` is 1; modulation resets to QPSK and version to 0.
- R2: With `mod_sel_i` = 2'b00 or 2'b11 (QPSK) every bit is output unchanged in order, whatever the version.
- R3: With `mod_sel_i` = 2'b01 (16QAM), bits form groups (v1,v2,v3,v4), counted from the first bit after the start pulse. Version 1 outputs v3,v4,v1,v2. Version 2 outputs v1,v2,~v3,~v4. Version 3 outputs v3,v4,~v1,~v2.
- R4: With `mod_sel_i` = 2'b10 (64QAM), bits form groups (v1..v6). Version 1 outputs v5,v6,~v3,~v4,v1,v2. Version 2 outputs v3,v4,~v5,~v6,v1,v2. Version 3 outputs v1,v2,~v3,~v4,v5,v6.
- R5: Version 0 leaves every 16QAM and 64QAM group unchanged.
- R6: Modulation and version are captured on `tti_start_i` only when no partial or pending group is held; a pulse at any other time has no effect on the output.
- R7: `out_last_o` is 1 on exactly the output bit that closes the TTI and 0 on every other bit.
- R8: If `in_last_i` arrives with an incomplete group, those bits are output unchanged and in order, and `err_partial_o` pulses for exactly one cycle; a complete final group raises no pulse.
- R9: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o`, `out_bit_o` and `out_last_o` hold; backpressure loses and duplicates no bit.
- R10: With both sides always ready, one bit is accepted every cycle, and the last output of an N-bit TTI leaves no more than N + group size cycles after the first input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tti_start_i | input | 1 | Pulse that captures the TTI configuration |
| mod_sel_i | input | 2 | Modulation: 00/11 QPSK, 01 16QAM, 10 64QAM |
| cver_i | input | 2 | Constellation version 0..3 |
| in_valid_i | input | 1 | Input bit valid |
| in_ready_o | output | 1 | Input bit accepted when valid |
| in_bit_i | input | 1 | Input bit |
| in_last_i | input | 1 | Marks the final bit of the TTI |
| out_valid_o | output | 1 | Output bit valid |
| out_ready_i | input | 1 | Downstream accepts the output bit |
| out_bit_o | output | 1 | Output bit |
| out_last_o | output | 1 | Marks the final output bit of the TTI |
| err_partial_o | output | 1 | One-cycle pulse when a TTI ends on an incomplete group |

## Verification
A wrong group counter shows up as a phase slip. Every later group of the TTI comes out permuted across the wrong boundary, so the stream differs from the model within one group length. A stale or wrongly captured configuration damages the first complete group after the start pulse. A wrong serializer index or length appears at the very next handshake as a duplicated or dropped bit, or as a misplaced `out_last_o`. The checks therefore compare whole streams under random backpressure, the position of the last flag, and the error pulse count at each TTI end.

// File: rtl/qra_pkg.sv
package qra_pkg;
  localparam int unsigned QRA_GRP_MAX = 6;
  localparam int unsigned QRA_CW      = $clog2(QRA_GRP_MAX + 1);

  typedef enum logic [1:0] {
    MOD_QPSK   = 2'b00,
    MOD_16QAM  = 2'b01,
    MOD_64QAM  = 2'b10,
    MOD_QPSK_B = 2'b11
  } mod_e;

  typedef struct packed {
    mod_e       mode;
    logic [1:0] ver;
  } cfg_t;

  function automatic logic [QRA_CW-1:0] grp_size(mod_e m);
    case (m)
      MOD_16QAM: return QRA_CW'(4);
      MOD_64QAM: return QRA_CW'(6);
      default:   return QRA_CW'(1);
    endcase
  endfunction
endpackage

// File: rtl/qra_cfg.sv
module qra_cfg
  import qra_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       idle_i,
  input  logic [1:0] mod_i,
  input  logic [1:0] ver_i,
  output cfg_t       cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.mode <= MOD_QPSK;
      cfg_q.ver  <= 2'd0;
    end else if (start_i && idle_i) begin
      cfg_q.mode <= mod_e'(mod_i);
      cfg_q.ver  <= ver_i;
    end
  end

  assign cfg_o = cfg_q;

  // R6: configuration frozen while a group is in flight
  a_r6_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && idle_i) |=> $stable(cfg_o));
endmodule

// File: rtl/qra_collect.sv
module qra_collect #(
  parameter int unsigned GRP_MAX = qra_pkg::QRA_GRP_MAX,
  parameter int unsigned CW      = qra_pkg::QRA_CW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic               in_bit_i,
  input  logic               in_last_i,
  input  logic [CW-1:0]      size_i,
  input  logic               take_i,
  output logic               ready_o,
  output logic               full_o,
  output logic [GRP_MAX-1:0] grp_o,
  output logic [CW-1:0]      len_o,
  output logic               last_o,
  output logic               idle_o,
  output logic               err_o
);
  localparam int unsigned IW = $clog2(GRP_MAX);

  logic [GRP_MAX-1:0] grp_q;
  logic [CW-1:0]      cnt_q, len_q, cnt_nxt;
  logic               full_q, last_q, err_q, acc;

  assign ready_o = !full_q || take_i;
  assign acc     = in_valid_i && ready_o;
  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q  <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      full_q <= 1'b0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (take_i) full_q <= 1'b0;
      if (acc) begin
        grp_q[cnt_q[IW-1:0]] <= in_bit_i;
        if (cnt_nxt == size_i || in_last_i) begin
          full_q <= 1'b1;
          cnt_q  <= '0;
          len_q  <= cnt_nxt;
          last_q <= in_last_i;
          err_q  <= (cnt_nxt != size_i);
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  assign full_o = full_q;
  assign grp_o  = grp_q;
  assign len_o  = len_q;
  assign last_o = last_q;
  assign idle_o = (cnt_q == '0) && !full_q;
  assign err_o  = err_q;

  // R3/R4: fill position never reaches the group size
  a_r3_cnt_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < size_i);
  // R8: error pulse only follows an accepted closing bit
  a_r8_err_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(acc && in_last_i));
endmodule

// File: rtl/qra_mapper.sv
module qra_mapper
  import qra_pkg::*;
#(
  parameter int unsigned GRP_MAX = QRA_GRP_MAX,
  parameter int unsigned CW      = QRA_CW
) (
  input  logic [GRP_MAX-1:0] grp_i,
  input  logic [CW-1:0]      len_i,
  input  logic [CW-1:0]      size_i,
  input  cfg_t               cfg_i,
  output logic [GRP_MAX-1:0] map_o
);
  // bit 0 is the first bit of the group on the wire
  always_comb begin
    map_o = grp_i;
    if (len_i == size_i) begin
      case (cfg_i.mode)
        MOD_16QAM: begin
          case (cfg_i.ver)
            2'd1:    map_o[3:0] = {grp_i[1], grp_i[0], grp_i[3], grp_i[2]};
            2'd2:    map_o[3:0] = {~grp_i[3], ~grp_i[2], grp_i[1], grp_i[0]};
            2'd3:    map_o[3:0] = {~grp_i[1], ~grp_i[0], grp_i[3], grp_i[2]};
            default: map_o = grp_i;
          endcase
        end
        MOD_64QAM: begin
          case (cfg_i.ver)
            2'd1:    map_o[5:0] = {grp_i[1], grp_i[0], ~grp_i[3], ~grp_i[2], grp_i[5], grp_i[4]};
            2'd2:    map_o[5:0] = {grp_i[1], grp_i[0], ~grp_i[5], ~grp_i[4], grp_i[3], grp_i[2]};
            2'd3:    map_o[5:0] = {grp_i[5], grp_i[4], ~grp_i[3], ~grp_i[2], grp_i[1], grp_i[0]};
            default: map_o = grp_i;
          endcase
        end
        default: map_o = grp_i;
      endcase
    end
  end

  // R3: a pure swap keeps the number of ones in the group
  always_comb begin
    if (cfg_i.mode == MOD_16QAM && cfg_i.ver == 2'd1 && len_i == size_i && !$isunknown(grp_i))
      a_r3_swap_weight: assert ($countones(map_o[3:0]) == $countones(grp_i[3:0]));
  end
endmodule

// File: rtl/qra_serial.sv
module qra_serial #(
  parameter int unsigned GRP_MAX = qra_pkg::QRA_GRP_MAX,
  parameter int unsigned CW      = qra_pkg::QRA_CW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [GRP_MAX-1:0] data_i,
  input  logic [CW-1:0]      len_i,
  input  logic               last_i,
  input  logic               out_ready_i,
  output logic               free_o,
  output logic               out_valid_o,
  output logic               out_bit_o,
  output logic               out_last_o
);
  localparam int unsigned IW = $clog2(GRP_MAX);

  logic [GRP_MAX-1:0] data_q;
  logic [CW-1:0]      len_q, idx_q;
  logic               busy_q, last_q, tail;

  assign tail   = (idx_q == len_q - 1'b1);
  assign free_o = !busy_q || (out_ready_i && tail);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else if (load_i) begin
      data_q <= data_i;
      len_q  <= len_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
      last_q <= last_i;
    end else if (busy_q && out_ready_i) begin
      if (tail) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  assign out_valid_o = busy_q;
  assign out_bit_o   = data_q[idx_q[IW-1:0]];
  assign out_last_o  = busy_q && last_q && tail;

  // R9: stalled output holds
  a_r9_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_bit_o) && $stable(out_last_o));
  // R10: replay index stays inside the loaded group
  a_r10_idx_in_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> idx_q < len_q);
endmodule

// File: rtl/qam_bit_rearranger.sv
module qam_bit_rearranger
  import qra_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tti_start_i,
  input  logic [1:0] mod_sel_i,
  input  logic [1:0] cver_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic       in_bit_i,
  input  logic       in_last_i,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic       out_bit_o,
  output logic       out_last_o,
  output logic       err_partial_o
);
  localparam int unsigned GM = QRA_GRP_MAX;
  localparam int unsigned CW = QRA_CW;

  cfg_t          cfg;
  logic [CW-1:0] size, col_len;
  logic [GM-1:0] col_grp, mapped;
  logic          col_full, col_last, col_idle, ser_free, take;

  assign size = grp_size(cfg.mode);
  assign take = col_full && ser_free;

  qra_cfg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tti_start_i),
    .idle_i  (col_idle),
    .mod_i   (mod_sel_i),
    .ver_i   (cver_i),
    .cfg_o   (cfg)
  );

  qra_collect #(.GRP_MAX(GM), .CW(CW)) i_collect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_bit_i   (in_bit_i),
    .in_last_i  (in_last_i),
    .size_i     (size),
    .take_i     (take),
    .ready_o    (in_ready_o),
    .full_o     (col_full),
    .grp_o      (col_grp),
    .len_o      (col_len),
    .last_o     (col_last),
    .idle_o     (col_idle),
    .err_o      (err_partial_o)
  );

  qra_mapper #(.GRP_MAX(GM), .CW(CW)) i_mapper (
    .grp_i  (col_grp),
    .len_i  (col_len),
    .size_i (size),
    .cfg_i  (cfg),
    .map_o  (mapped)
  );

  qra_serial #(.GRP_MAX(GM), .CW(CW)) i_serial (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (take),
    .data_i      (mapped),
    .len_i       (col_len),
    .last_i      (col_last),
    .out_ready_i (out_ready_i),
    .free_o      (ser_free),
    .out_valid_o (out_valid_o),
    .out_bit_o   (out_bit_o),
    .out_last_o  (out_last_o)
  );

  // R1: nothing emitted or flagged straight out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_valid_o && !err_partial_o);
endmodule

// File: tb/test_qam_bit_rearranger.sv
module test_qam_bit_rearranger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tti_start = 1'b0;
  logic [1:0] mod_sel = 2'b00, cver = 2'b00;
  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, out_last, err_partial;

  always #2 clk = ~clk;

  qam_bit_rearranger i_qam_bit_rearranger (
    .clk_i(clk), .rst_ni(rst_n), .tti_start_i(tti_start), .mod_sel_i(mod_sel),
    .cver_i(cver), .in_valid_i(in_valid), .in_ready_o(in_ready), .in_bit_i(in_bit),
    .in_last_i(in_last), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_bit_o(out_bit), .out_last_o(out_last), .err_partial_o(err_partial));

  int n_cmp = 0, n_bad = 0, cyc = 0, err_cnt = 0;
  int t_first_acc = -1, t_last_out = -1;
  bit got_q[$];
  bit got_last[$];
  bit bp_en = 1'b0, hold_pend = 1'b0, hold_bit = 1'b0, hold_last = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (hold_pend)
        chk(out_valid && out_bit == hold_bit && out_last == hold_last, "R9", "stalled output held",
            {out_valid, out_bit}, {1'b1, hold_bit});
      hold_pend = out_valid && !out_ready;
      hold_bit  = out_bit;
      hold_last = out_last;
      if (out_valid && out_ready) begin
        got_q.push_back(out_bit);
        got_last.push_back(out_last);
        t_last_out = cyc;
      end
      if (in_valid && in_ready && t_first_acc < 0) t_first_acc = cyc;
      if (err_partial) err_cnt++;
    end
    if (cyc == 150000) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic int gsz(int md);
    return (md == 1) ? 4 : (md == 2) ? 6 : 1;
  endfunction

  // model straight from R2..R5 and R8
  function automatic void model(input bit src[$], input int md, input int vr, output bit dst[$]);
    int g = gsz(md);
    int n = src.size();
    dst = {};
    for (int b = 0; b < n; b += g) begin
      int perm[6];
      bit inv[6];
      for (int i = 0; i < 6; i++) begin perm[i] = i; inv[i] = 0; end
      if (b + g <= n) begin
        if (md == 1) begin
          if (vr == 1) begin perm[0]=2; perm[1]=3; perm[2]=0; perm[3]=1; end
          if (vr == 2) begin inv[2]=1; inv[3]=1; end
          if (vr == 3) begin perm[0]=2; perm[1]=3; perm[2]=0; perm[3]=1; inv[2]=1; inv[3]=1; end
        end else if (md == 2) begin
          if (vr == 1) begin perm[0]=4; perm[1]=5; perm[4]=0; perm[5]=1; inv[2]=1; inv[3]=1; end
          if (vr == 2) begin perm[0]=2; perm[1]=3; perm[2]=4; perm[3]=5; perm[4]=0; perm[5]=1; inv[2]=1; inv[3]=1; end
          if (vr == 3) begin inv[2]=1; inv[3]=1; end
        end
        for (int i = 0; i < g; i++) dst.push_back(src[b + perm[i]] ^ inv[i]);
      end else begin
        for (int i = b; i < n; i++) dst.push_back(src[i]);
      end
    end
  endfunction

  task automatic pulse_start(int md, int vr);
    @(posedge clk); #1;
    tti_start = 1'b1; mod_sel = md[1:0]; cver = vr[1:0];
    @(posedge clk); #1;
    tti_start = 1'b0;
  endtask

  task automatic send_bit(bit b, bit last, bit gaps);
    in_valid = 1'b1; in_bit = b; in_last = last;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    if (gaps && ($urandom % 3) == 0) begin
      in_valid = 1'b0;
      repeat ($urandom % 3) begin @(posedge clk); #1; end
    end
  endtask

  task automatic run_tti(int md, int vr, int n, bit bp, bit mid_start, string req);
    bit src[$];
    bit exp_q[$];
    int mis = -1, lastpos = -1, nlast = 0, wait_c = 0;
    for (int i = 0; i < n; i++) src.push_back(1'($urandom % 2));
    model(src, md, vr, exp_q);
    pulse_start(md, vr);
    got_q = {}; got_last = {}; err_cnt = 0; t_first_acc = -1; t_last_out = -1;
    bp_en = bp;
    for (int i = 0; i < n; i++) begin
      send_bit(src[i], i == n - 1, bp);
      if (mid_start && i == 1) begin
        in_valid = 1'b0;
        pulse_start((md == 2) ? 1 : 2, 3 - vr);
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    while (got_q.size() < n && wait_c < 5000) begin @(posedge clk); wait_c++; end
    repeat (4) @(posedge clk);
    bp_en = 1'b0;
    for (int i = 0; i < n && i < got_q.size(); i++)
      if (mis < 0 && got_q[i] != exp_q[i]) mis = i;
    for (int i = 0; i < got_last.size(); i++)
      if (got_last[i]) begin nlast++; lastpos = i; end
    chk(got_q.size() == n, req, "output bit count", got_q.size(), n);
    chk(mis < 0, req, "first mismatching bit index", mis, -1);
    chk(nlast == 1 && lastpos == n - 1, "R7", "last flag position", lastpos, n - 1);
    chk(err_cnt == ((n % gsz(md)) != 0 ? 1 : 0), "R8", "partial error pulses",
        err_cnt, (n % gsz(md)) != 0 ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready && !err_partial, "R1", "reset state valid/ready/err",
        {out_valid, in_ready, err_partial}, 3'b010);

    run_tti(0, 3, 13, 0, 0, "R2");
    run_tti(3, 2, 9, 1, 0, "R2");
    run_tti(1, 0, 16, 0, 0, "R5");
    run_tti(2, 0, 18, 1, 0, "R5");
    run_tti(1, 1, 12, 1, 0, "R3");
    run_tti(1, 2, 12, 0, 0, "R3");
    run_tti(1, 3, 16, 1, 0, "R3");
    run_tti(2, 1, 18, 0, 0, "R4");
    run_tti(2, 2, 24, 1, 0, "R4");
    run_tti(2, 3, 12, 1, 0, "R4");
    run_tti(1, 3, 10, 1, 0, "R8");
    run_tti(2, 1, 4, 0, 0, "R8");
    run_tti(2, 2, 1, 1, 0, "R8");
    run_tti(1, 1, 12, 0, 1, "R6");
    run_tti(2, 2, 18, 1, 1, "R6");

    run_tti(2, 1, 60, 0, 0, "R10");
    chk(t_first_acc >= 0 && (t_last_out - t_first_acc) <= 60 + 6, "R10", "cycles for 60 bits",
        t_last_out - t_first_acc, 66);
    run_tti(1, 3, 40, 0, 0, "R10");
    chk(t_first_acc >= 0 && (t_last_out - t_first_acc) <= 40 + 4, "R10", "cycles for 40 bits",
        t_last_out - t_first_acc, 44);

    for (int t = 0; t < 24; t++) begin
      int md = $urandom % 4;
      int vr = $urandom % 4;
      int g = gsz(md);
      int n = g * (1 + $urandom % 8);
      if (($urandom % 5) == 0 && g > 1) n = n + 1 + ($urandom % (g - 1));
      run_tti(md, vr, n, 1'($urandom % 2), 0, (md == 1) ? "R3" : (md == 2) ? "R4" : "R2");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule